// File: doc/BRIEF.md
# Time-Sample Word Stream Formatter

This block turns the digitized samples of one front-end board into a 16-bit word stream, one time sample at a time. A producer offers a complete sample through a valid/ready handshake. The sample holds 96 ADC values, each with an active-low overlap flag, a 16-bit per-event side field, two 12-bit status fields and a flag that says the sample memory was full. The block stores the sample and then emits its words through a second valid/ready handshake. A sample that is not full produces 100 words. A full sample produces a short fixed error pattern instead.

Channel words leave in a fixed layer/channel permutation. Each channel word carries one bit of the side field on bit 13. After the 96 channel words come a CRC word over the ADC bits, two status words and a filler word. An event is 16 or 8 samples long. The length is taken from the side field of the event's first sample and kept until the event ends.

Top module: `stf_sample_formatter`

## Requirements
- R1: After reset, `s_ready` is 1 and `o_valid`, `o_sample_last` and `o_event_last` are 0. A sample is taken in on a clock edge where `s_valid` and `s_ready` are both 1. From the next cycle `o_valid` is 1 and `s_ready` is 0 until the last word of the sample has been taken.
- R2: A sample that is not full is sent as 100 words: 96 channel words, then the CRC word, then status word A, then status word B, then the constant 0x7FFF. `o_sample_last` is 1 only while word 100 is on `o_data`.
- R3: A channel word is {0, overlap_n, side bit, ADC[12:0]}. Bit 15 is 0, bit 14 is the overlap flag of that input slot as given, and bits 12:0 are the ADC value.
- R4: Channel word k (0..95) belongs to group g = k/6 and position p = k%6. Its layer is taken from position p in the order 3,1,5,6,4,2. Its channel is taken from group g in the order 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8. Layer L (1..6) and channel c read input slot s = (L-1)*16+c, which is `s_adc[s*13 +: 13]` and `s_ovl_n[s]`.
- R5: Bit 13 of every channel word in group g equals bit g of the side field `s_info`.
- R6: The CRC word is {0, crc[14:0]}. The CRC starts at zero for every sample and takes in bits 12:0 of the 96 channel words, least significant bit first. For each bit d the step is: fb = crc[14]^d; crc = {crc[13:0],0}; if fb is 1, crc ^= 0x0003. This is the polynomial x^15+x+1.
- R7: Status word A is {0111, `s_stat_a`} and status word B is {0111, `s_stat_b`}.
- R8: A sample taken in with `s_mem_full`=1 is sent as exactly four words, each 0xB200 (bit 15 set, bits 15:9 = 1011001, rest 0). `o_sample_last` is 1 on the fourth word.
- R9: Bit 15 of `s_info` on the first sample of an event selects 16 samples (1) or 8 samples (0). Bit 15 on later samples of the same event has no effect on the length. `o_event_last` is 1 only on the last word of the event's last sample. Reset starts a new event.
- R10: While `o_valid` is 1 and `o_ready` is 0, `o_valid` stays 1 and `o_data` stays unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Block can take a sample |
| s_adc | input | 1248 | 96 ADC values, 13 bits each, by input slot |
| s_ovl_n | input | 96 | Active-low overlap flag per input slot |
| s_info | input | 16 | Per-event side field; bit 15 is the 16-sample flag |
| s_stat_a | input | 12 | Status field for word 98 |
| s_stat_b | input | 12 | Status field for word 99 |
| s_mem_full | input | 1 | Sample memory full; send the error pattern |
| o_valid | output | 1 | Output word valid |
| o_ready | input | 1 | Consumer takes the word |
| o_data | output | 16 | Output word |
| o_sample_last | output | 1 | Last word of a sample |
| o_event_last | output | 1 | Last word of an event |

## Verification
The assertions watch several properties on every clock edge:
- a stalled word stays fixed;
- intake is followed by output;
- the error pattern never runs past four words and never shows another value;
- channel words keep bit 15 low;
- the word counter stays in range;
- the CRC is cleared when a sample is taken in;
- the event length stays put in the middle of an event.

Some behaviour only the bench scenarios can show. These are the exact permutation of slots to words, the placement of the side bits, the CRC value, the status words, and where the event ends under both lengths, including mixed full samples and a reset in the middle of an event.

// File: rtl/stf_pkg.sv
// Shared constants and helper functions for the time-sample formatter.
// Assumes a 16-bit output word, 13-bit ADC values and 12-bit status fields.
package stf_pkg;
    localparam int WORD_W = 16;
    localparam int ADC_W  = 13;
    localparam int STAT_W = 12;
    localparam int CRC_W  = 15;

    localparam logic [CRC_W-1:0]  CRC_POLY    = 15'h0003;
    localparam logic [WORD_W-1:0] FILL_WORD   = 16'h7FFF;
    localparam logic [WORD_W-1:0] FULL_WORD   = 16'hB200;
    localparam logic [3:0]        STAT_PREFIX = 4'b0111;

    // Channel carried by group g: reflected binary order.
    function automatic int grp_channel(input int g);
        return g ^ (g >> 1);
    endfunction

    // Layer number (1-based) carried at position p inside a group.
    function automatic int layer_at(input int p);
        case (p)
            0: return 3;
            1: return 1;
            2: return 5;
            3: return 6;
            4: return 4;
            5: return 2;
            default: return p + 1;
        endcase
    endfunction

    // Feed one ADC value into the CRC, lowest bit first.
    function automatic logic [CRC_W-1:0] crc_feed(input logic [CRC_W-1:0] c,
                                                  input logic [ADC_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < ADC_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/stf_seq.sv
// Sequencer: owns both handshakes, the word/group/position counters, the
// sample counter within an event and the latched event length.
// Assumes the producer holds s_valid and data steady until accepted.
module stf_seq
    import stf_pkg::*;
#(
    parameter int NGRP   = 16,
    parameter int NLAYER = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          s_valid,
    output logic                          s_ready,
    output logic                          load,
    input  logic                          mem_full_in,
    input  logic                          mode_in,
    output logic                          o_valid,
    input  logic                          o_ready,
    output logic [$clog2(NGRP*NLAYER+4)-1:0] word_idx,
    output logic [$clog2(NGRP)-1:0]       grp,
    output logic [$clog2(NLAYER)-1:0]     pos,
    output logic                          full_hold,
    output logic                          sample_last,
    output logic                          event_last
);
    localparam int NCHW   = NGRP * NLAYER;
    localparam int NWORD  = NCHW + 4;
    localparam int WIDX_W = $clog2(NWORD);
    localparam int SMP_W  = 4;
    localparam int NFULLW = 4;

    logic             busy;
    logic             mode16;
    logic [SMP_W-1:0] smp_cnt;
    logic             fire;
    logic             last_word;
    logic             last_smp;

    // Handshake and terminal-count decode.
    always_comb begin
        s_ready     = !busy;
        load        = s_valid && !busy;
        o_valid     = busy;
        fire        = busy && o_ready;
        last_word   = full_hold ? (word_idx == WIDX_W'(NFULLW-1))
                                : (word_idx == WIDX_W'(NWORD-1));
        last_smp    = mode16 ? (smp_cnt == SMP_W'(15)) : (smp_cnt == SMP_W'(7));
        sample_last = busy && last_word;
        event_last  = busy && last_word && last_smp;
    end

    // Counter and state updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            word_idx  <= '0;
            grp       <= '0;
            pos       <= '0;
            full_hold <= 1'b0;
            smp_cnt   <= '0;
            mode16    <= 1'b0;
        end else if (load) begin
            busy      <= 1'b1;
            word_idx  <= '0;
            grp       <= '0;
            pos       <= '0;
            full_hold <= mem_full_in;
            if (smp_cnt == '0) mode16 <= mode_in;
        end else if (fire) begin
            if (last_word) begin
                busy    <= 1'b0;
                smp_cnt <= last_smp ? '0 : smp_cnt + 1'b1;
            end else begin
                word_idx <= word_idx + 1'b1;
                if (word_idx < WIDX_W'(NCHW-1)) begin
                    if (pos == $bits(pos)'(NLAYER-1)) begin
                        pos <= '0;
                        grp <= grp + 1'b1;
                    end else begin
                        pos <= pos + 1'b1;
                    end
                end
            end
        end
    end

    assert_intake_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (o_valid && !s_ready));
    assert_word_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (word_idx < WIDX_W'(NWORD)));
    assert_full_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && full_hold) |-> (word_idx < WIDX_W'(NFULLW)));
    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_cnt != '0) |=> $stable(mode16));
endmodule

// File: rtl/stf_word_build.sv
// Sample holding registers and the output word multiplexer.
// Applies the layer/channel permutation and places the side bit, CRC,
// status and filler words. Assumes counters come from stf_seq.
module stf_word_build
    import stf_pkg::*;
#(
    parameter int NGRP   = 16,
    parameter int NLAYER = 6
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [NGRP*NLAYER*ADC_W-1:0]     s_adc,
    input  logic [NGRP*NLAYER-1:0]           s_ovl_n,
    input  logic [NGRP-1:0]                  s_info,
    input  logic [STAT_W-1:0]                s_stat_a,
    input  logic [STAT_W-1:0]                s_stat_b,
    input  logic [$clog2(NGRP*NLAYER+4)-1:0] word_idx,
    input  logic [$clog2(NGRP)-1:0]          grp,
    input  logic [$clog2(NLAYER)-1:0]        pos,
    input  logic                             full_hold,
    input  logic [CRC_W-1:0]                 crc_val,
    output logic [WORD_W-1:0]                o_word
);
    localparam int NCHW   = NGRP * NLAYER;
    localparam int WIDX_W = $clog2(NCHW + 4);

    logic [NCHW*ADC_W-1:0] adc_q;
    logic [NCHW-1:0]       ovl_q;
    logic [NGRP-1:0]       info_q;
    logic [STAT_W-1:0]     sa_q;
    logic [STAT_W-1:0]     sb_q;
    int                    slot;

    // Capture the offered sample on intake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_q  <= '0;
            ovl_q  <= '0;
            info_q <= '0;
            sa_q   <= '0;
            sb_q   <= '0;
        end else if (load) begin
            adc_q  <= s_adc;
            ovl_q  <= s_ovl_n;
            info_q <= s_info;
            sa_q   <= s_stat_a;
            sb_q   <= s_stat_b;
        end
    end

    // Select the word for the current index.
    always_comb begin
        slot = (layer_at(int'(pos)) - 1) * NGRP + grp_channel(int'(grp));
        if (full_hold) begin
            o_word = FULL_WORD;
        end else if (word_idx < WIDX_W'(NCHW)) begin
            o_word = {1'b0, ovl_q[slot], info_q[grp], adc_q[slot*ADC_W +: ADC_W]};
        end else if (word_idx == WIDX_W'(NCHW)) begin
            o_word = {1'b0, crc_val};
        end else if (word_idx == WIDX_W'(NCHW+1)) begin
            o_word = {STAT_PREFIX, sa_q};
        end else if (word_idx == WIDX_W'(NCHW+2)) begin
            o_word = {STAT_PREFIX, sb_q};
        end else begin
            o_word = FILL_WORD;
        end
    end

    assert_chan_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_hold && word_idx < WIDX_W'(NCHW)) |-> (o_word[WORD_W-1] == 1'b0));
endmodule

// File: rtl/stf_crc.sv
// Running CRC over the ADC bits of the channel words of one sample.
// Cleared on intake, advanced once per accepted channel word.
module stf_crc
    import stf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [ADC_W-1:0] din,
    output logic [CRC_W-1:0] crc
);
    // Update the CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= '0;
        else if (clear)   crc <= '0;
        else if (advance) crc <= crc_feed(crc, din);
    end

    assert_crc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == '0));
endmodule

// File: rtl/stf_sample_formatter.sv
// Top level: takes one time sample per handshake and streams its words.
// Connects the sequencer, the word builder and the CRC unit.
module stf_sample_formatter
    import stf_pkg::*;
#(
    parameter int NGRP   = 16,
    parameter int NLAYER = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_valid,
    output logic                         s_ready,
    input  logic [NGRP*NLAYER*ADC_W-1:0] s_adc,
    input  logic [NGRP*NLAYER-1:0]       s_ovl_n,
    input  logic [NGRP-1:0]              s_info,
    input  logic [STAT_W-1:0]            s_stat_a,
    input  logic [STAT_W-1:0]            s_stat_b,
    input  logic                         s_mem_full,
    output logic                         o_valid,
    input  logic                         o_ready,
    output logic [WORD_W-1:0]            o_data,
    output logic                         o_sample_last,
    output logic                         o_event_last
);
    localparam int NCHW   = NGRP * NLAYER;
    localparam int WIDX_W = $clog2(NCHW + 4);
    localparam int GRP_W  = $clog2(NGRP);
    localparam int POS_W  = $clog2(NLAYER);

    logic              load;
    logic [WIDX_W-1:0] word_idx;
    logic [GRP_W-1:0]  grp;
    logic [POS_W-1:0]  pos;
    logic              full_hold;
    logic [CRC_W-1:0]  crc_val;
    logic              crc_adv;

    stf_seq #(.NGRP(NGRP), .NLAYER(NLAYER)) u_seq (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .load(load), .mem_full_in(s_mem_full), .mode_in(s_info[NGRP-1]),
        .o_valid(o_valid), .o_ready(o_ready), .word_idx(word_idx),
        .grp(grp), .pos(pos), .full_hold(full_hold),
        .sample_last(o_sample_last), .event_last(o_event_last)
    );

    stf_word_build #(.NGRP(NGRP), .NLAYER(NLAYER)) u_build (
        .clk(clk), .rst_n(rst_n), .load(load), .s_adc(s_adc),
        .s_ovl_n(s_ovl_n), .s_info(s_info), .s_stat_a(s_stat_a),
        .s_stat_b(s_stat_b), .word_idx(word_idx), .grp(grp), .pos(pos),
        .full_hold(full_hold), .crc_val(crc_val), .o_word(o_data)
    );

    // Advance the CRC on each accepted channel word.
    always_comb crc_adv = o_valid && o_ready && !full_hold && (word_idx < WIDX_W'(NCHW));

    stf_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(load), .advance(crc_adv),
        .din(o_data[ADC_W-1:0]), .crc(crc_val)
    );

    assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));
    assert_fill_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (o_sample_last && !full_hold) |-> (o_data == FILL_WORD));
    assert_full_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && full_hold) |-> (o_data == FULL_WORD));
    assert_event_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        o_event_last |-> o_sample_last);
endmodule

// File: tb/stf_sample_formatter_bench.sv
module stf_sample_formatter_bench;
    localparam int CLK_P = 10;
    localparam int NCH   = 96;
    localparam int N_EV  = 5;

    // Event table: first-sample side field, full-sample mask, seed,
    // stall style, expected sample count.
    localparam logic [15:0] EV_INFO [N_EV] = '{16'h0A35, 16'h8C4B, 16'h00F1, 16'h8FFF, 16'h7000};
    localparam logic [15:0] EV_FULL [N_EV] = '{16'h0000, 16'h0000, 16'h0024, 16'h8001, 16'h00FF};
    localparam int          EV_SEED [N_EV] = '{3, 17, 41, 5, 99};
    localparam int          EV_STALL[N_EV] = '{0, 1, 0, 2, 1};
    localparam int          EV_NSMP [N_EV] = '{8, 16, 8, 16, 8};

    localparam int CHT[16] = '{0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8};
    localparam int LYT[6]  = '{3,1,5,6,4,2};

    logic clk = 0;
    logic rst_n = 0;
    logic s_valid = 0;
    logic s_ready;
    logic [NCH*13-1:0] s_adc = '0;
    logic [NCH-1:0] s_ovl_n = '0;
    logic [15:0] s_info = '0;
    logic [11:0] s_stat_a = '0, s_stat_b = '0;
    logic s_mem_full = 0;
    logic o_valid;
    logic o_ready = 0;
    logic [15:0] o_data;
    logic o_sample_last, o_event_last;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    logic [12:0] b_adc [NCH];
    logic        b_ovl [NCH];
    logic [15:0] b_info;
    logic [11:0] b_sa, b_sb;
    logic        b_full;

    stf_sample_formatter u_stf_sample_formatter (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_adc(s_adc), .s_ovl_n(s_ovl_n), .s_info(s_info),
        .s_stat_a(s_stat_a), .s_stat_b(s_stat_b), .s_mem_full(s_mem_full),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
        .o_sample_last(o_sample_last), .o_event_last(o_event_last)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] crc_ref(input logic [14:0] c, input logic [12:0] d);
        logic [14:0] r = c;
        for (int i = 0; i < 13; i++) begin
            logic fb = r[14] ^ d[i];
            r = {r[13:0], 1'b0};
            if (fb) r = r ^ 15'h0003;
        end
        return r;
    endfunction

    // Build sample n of event ev and drive it on the inputs.
    task automatic make_sample(input int ev, input int n);
        int sd = EV_SEED[ev];
        for (int s = 0; s < NCH; s++) begin
            if (sd == 5) begin
                b_adc[s] = 13'h1FFF;
                b_ovl[s] = 1'b0;
            end else begin
                b_adc[s] = 13'((sd*1237 + n*311 + s*97) ^ (s << 7));
                b_ovl[s] = (^b_adc[s]) ^ n[0];
            end
            s_adc[s*13 +: 13] = b_adc[s];
            s_ovl_n[s] = b_ovl[s];
        end
        if (n == 0) b_info = EV_INFO[ev];
        else begin
            b_info = EV_INFO[ev] ^ 16'(n * 16'h0111);
            b_info[15] = ~EV_INFO[ev][15];
        end
        b_sa   = 12'(sd*53 + n*7);
        b_sb   = 12'(~(sd + n*129));
        b_full = EV_FULL[ev][n];
        s_info = b_info; s_stat_a = b_sa; s_stat_b = b_sb; s_mem_full = b_full;
    endtask

    function automatic logic [15:0] exp_word(input int k, input logic [14:0] crc);
        int g, p, sl;
        if (b_full) return 16'hB200;
        if (k < 96) begin
            g = k / 6; p = k % 6;
            sl = (LYT[p] - 1) * 16 + CHT[g];
            return {1'b0, b_ovl[sl], b_info[g], b_adc[sl]};
        end
        if (k == 96) return {1'b0, crc};
        if (k == 97) return {4'h7, b_sa};
        if (k == 98) return {4'h7, b_sb};
        return 16'h7FFF;
    endfunction

    function automatic bit rdy_for(input int st);
        if (st == 1) return (cyc % 3) != 0;
        if (st == 2) return (cyc % 4) >= 2;
        return 1'b1;
    endfunction

    // Offer one sample, then collect and check all of its words.
    // If abort_at >= 0, stop after that many words without finishing.
    task automatic run_sample(input int ev, input int n, input int abort_at);
        int nw, k;
        logic [14:0] crc;
        logic [15:0] prev, ew;
        bit stalled;
        make_sample(ev, n);
        s_valid = 1;
        while (!s_ready) begin @(negedge clk); cyc++; end
        @(negedge clk); cyc++;
        s_valid = 0;
        chk(o_valid && !s_ready, "R1 intake: valid up, ready down", {14'b0, o_valid, s_ready}, 16'h0002);
        nw = b_full ? 4 : 100;
        k = 0; crc = '0; stalled = 0; prev = '0;
        while (k < nw && k != abort_at) begin
            bit r = rdy_for(EV_STALL[ev]);
            o_ready = r;
            if (stalled) chk(o_valid && o_data == prev, "R10 stalled word held", o_data, prev);
            ew = exp_word(k, crc);
            if (r) begin
                string tag;
                if (b_full) tag = "R8 full pattern";
                else if (k < 96) tag = "R3 R4 R5 channel word";
                else if (k == 96) tag = "R6 crc word";
                else if (k < 99) tag = "R7 status word";
                else tag = "R2 filler word";
                chk(o_valid && o_data == ew, tag, o_data, ew);
                chk(o_sample_last == (k == nw-1), "R2 R8 sample_last position",
                    {15'b0, o_sample_last}, {15'b0, k == nw-1});
                if (k == nw-1)
                    chk(o_event_last == (n == EV_NSMP[ev]-1), "R9 event_last",
                        {15'b0, o_event_last}, {15'b0, n == EV_NSMP[ev]-1});
                else
                    chk(!o_event_last, "R9 event_last early", {15'b0, o_event_last}, 16'h0);
                if (!b_full && k < 96) crc = crc_ref(crc, ew[12:0]);
                k++;
                stalled = 0;
            end else begin
                stalled = 1;
                prev = o_data;
            end
            @(negedge clk); cyc++;
        end
        o_ready = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(s_ready && !o_valid && !o_sample_last && !o_event_last, "R1 reset state",
            {12'b0, s_ready, o_valid, o_sample_last, o_event_last}, 16'h0008);
        rst_n = 1;
        @(negedge clk);
        chk(s_ready && !o_valid, "R1 idle after reset", {14'b0, s_ready, o_valid}, 16'h0002);

        // Table walk: each event runs its expected number of samples.
        for (int ev = 0; ev < N_EV; ev++)
            for (int n = 0; n < EV_NSMP[ev]; n++)
                run_sample(ev, n, -1);

        // Directed: reset in the middle of a 16-sample event.
        run_sample(1, 0, -1);
        run_sample(1, 1, 37);
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk(!o_valid && s_ready && !o_sample_last, "R1 reset mid-sample",
            {13'b0, o_valid, s_ready, o_sample_last}, 16'h0002);
        rst_n = 1;
        @(negedge clk);
        // A fresh 8-sample event must end after 8 samples (R9).
        for (int n = 0; n < 8; n++) run_sample(0, n, -1);
        @(negedge clk);
        chk(s_ready && !o_valid, "R1 idle after last sample", {14'b0, s_ready, o_valid}, 16'h0002);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule